// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Entry Locking

This block stores up to 64 translation entries. Each entry pairs a 64-bit tag with a 64-bit data word. Bit 63 of the data word marks the entry valid, and bit 6 marks it locked. Software-style register writes manage the buffer. A staging register holds the tag for the next entry and is loaded by its own write. An allocating write then places the entry: it takes the lowest invalid slot, or else the lowest unlocked slot. If every slot is both valid and locked, the write is dropped. A direct write selects a slot by address index and overwrites it whatever state it is in.

A tag read searches every valid entry for an exact 64-bit tag match. It reports the tag and the slot index of the lowest matching entry. On a miss it returns zero. All requests are single-cycle with no back-pressure. Every write takes effect at the clock edge that accepts it, and a tag-read result appears one cycle after the request.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, so a tag read of any value misses. The response output is low until a tag read has been accepted.
- R2: A request is accepted on each rising clock edge where `req_valid` is high. The operation code `req_op` selects the operation: 0 loads the tag staging register from `req_wdata`, 1 is an allocating write, 2 is a direct write and 3 is a tag read. When `req_valid` is low, nothing changes.
- R3: An allocating write stores the staging register as the tag and `req_wdata` as the data word, in the lowest-indexed entry whose data bit 63 is 0.
- R4: When no entry is invalid, an allocating write goes to the lowest-indexed entry whose data bit 6 is 0.
- R5: When every entry has data bit 63 set and bit 6 set, an allocating write changes no entry.
- R6: A direct write stores the staging tag and `req_wdata` in the entry selected by `req_addr[8:3]`, regardless of that entry's valid or lock bits. The other address bits are ignored.
- R7: A tag read whose value `req_wdata` equals the tag of a valid entry gives, in the next cycle, `rsp_valid`=1, `rsp_hit`=1, `rsp_tag` equal to that tag, and `rsp_idx` set to the lowest such entry index. On a miss it gives `rsp_hit`=0, `rsp_tag`=0 and `rsp_idx`=0.
- R8: An entry whose data bit 63 is 0 never matches a tag read, even when its tag is equal to the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request accepted on this edge |
| req_op | input | 2 | 0 tag stage, 1 allocate, 2 direct, 3 tag read |
| req_addr | input | 16 | Address; bits [8:3] index a direct write |
| req_wdata | input | 64 | Tag or data word, or the tag value to search for |
| rsp_valid | output | 1 | Tag-read result present |
| rsp_hit | output | 1 | Tag read found a valid match |
| rsp_idx | output | 6 | Index of the matching entry |
| rsp_tag | output | 64 | Matching tag, zero on a miss |

## Verification
The bench fills the buffer so that a single unlocked slot sits in the middle. It then checks that allocation lands there and not on slot 0. A design that ignored the lock bit would evict a locked entry. Once every slot is locked, a further allocating write must vanish; a design that fell through to a default slot would overwrite entry 0 or entry 63. Holes punched by direct writes must be refilled lowest first, ahead of any unlocked replacement. Invalid entries that carry the searched tag must not hit. A buffer holding duplicate tags must report the lower index, and a wrong encoder direction would report the higher one.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 64,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 16,
  parameter int VLD_BIT = 63,
  parameter int LCK_BIT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [$clog2(ENTRIES)-1:0] rsp_idx,
  output logic [TAG_W-1:0]           rsp_tag
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] OP_STAGE = 2'd0, OP_ALLOC = 2'd1, OP_DIRECT = 2'd2, OP_READ = 2'd3;

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];
  logic [TAG_W-1:0]  stage_q;

  logic          free_ok, open_ok, hit_ok;
  logic [IW-1:0] free_idx, open_idx, hit_idx;

  always_comb begin
    free_ok = 1'b0; free_idx = '0;
    open_ok = 1'b0; open_idx = '0;
    hit_ok  = 1'b0; hit_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!data_q[i][VLD_BIT]) begin free_ok = 1'b1; free_idx = IW'(i); end
      if (!data_q[i][LCK_BIT]) begin open_ok = 1'b1; open_idx = IW'(i); end
      if (data_q[i][VLD_BIT] && tag_q[i] == TAG_W'(req_wdata)) begin
        hit_ok = 1'b1; hit_idx = IW'(i);
      end
    end
  end

  wire          do_stage  = req_valid && req_op == OP_STAGE;
  wire          do_alloc  = req_valid && req_op == OP_ALLOC;
  wire          do_direct = req_valid && req_op == OP_DIRECT;
  wire          do_read   = req_valid && req_op == OP_READ;
  wire [IW-1:0] dir_idx   = req_addr[IW+2:3];
  wire          wr_en     = do_direct || (do_alloc && (free_ok || open_ok));
  wire [IW-1:0] wr_idx    = do_direct ? dir_idx : (free_ok ? free_idx : open_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      stage_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_tag   <= '0;
    end else begin
      if (do_stage) stage_q <= TAG_W'(req_wdata);
      if (wr_en) begin
        tag_q[wr_idx]  <= stage_q;
        data_q[wr_idx] <= req_wdata;
      end
      rsp_valid <= do_read;
      if (do_read) begin
        rsp_hit <= hit_ok;
        rsp_idx <= hit_ok ? hit_idx : '0;
        rsp_tag <= hit_ok ? TAG_W'(req_wdata) : '0;
      end
    end
  end

  p_rsp_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_op == OP_READ));
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_tag == '0 && rsp_idx == '0));
  p_hit_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (data_q[rsp_idx][VLD_BIT] && tag_q[rsp_idx] == rsp_tag));
  p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && free_ok) |=> (data_q[$past(free_idx)] == $past(req_wdata)
                               && tag_q[$past(free_idx)] == $past(stage_q)));
  p_alloc_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !free_ok && open_ok) |=> data_q[$past(open_idx)] == $past(req_wdata));
  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_direct |=> data_q[$past(dir_idx)] == $past(req_wdata));
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !free_ok && !open_ok) |=> $stable(data_q[0]) && $stable(data_q[ENTRIES-1]));
endmodule

// File: tb/sim_tlb_assoc.sv
module sim_tlb_assoc;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000, L = 64'h40;
  localparam logic [63:0] TA = 64'h0123_4567_89AB_CDEF, TB = 64'hFEDC_BA98_7654_3210, TC = 64'h0C0C;
  localparam logic [1:0] STG = 2'd0, ALC = 2'd1, DIR = 2'd2, RD = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [63:0] wd;
    logic        chk;
    logic        hit;
    logic [5:0]  idx;
    logic [63:0] tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{STG, 16'h0,    TA,    1'b0, 1'b0, 6'd0, 64'd0},
    '{ALC, 16'h0,    V|1,   1'b0, 1'b0, 6'd0, 64'd0},  // R3 -> entry 0
    '{STG, 16'h0,    TB,    1'b0, 1'b0, 6'd0, 64'd0},
    '{ALC, 16'h0,    V|L,   1'b0, 1'b0, 6'd0, 64'd0},  // R3 -> entry 1
    '{RD,  16'h0,    TA,    1'b1, 1'b1, 6'd0, TA},     // R7
    '{RD,  16'h0,    TB,    1'b1, 1'b1, 6'd1, TB},     // R7
    '{RD,  16'h0,    TC,    1'b1, 1'b0, 6'd0, 64'd0},  // R7 miss
    '{STG, 16'h0,    TC,    1'b0, 1'b0, 6'd0, 64'd0},
    '{DIR, 16'h28,   64'd0, 1'b0, 1'b0, 6'd0, 64'd0},  // R6 entry 5, invalid
    '{RD,  16'h0,    TC,    1'b1, 1'b0, 6'd0, 64'd0},  // R8
    '{DIR, 16'h7E18, V,     1'b0, 1'b0, 6'd0, 64'd0},  // R6 entry 3, high bits ignored
    '{DIR, 16'h38,   V,     1'b0, 1'b0, 6'd0, 64'd0},  // R6 entry 7
    '{RD,  16'h0,    TC,    1'b1, 1'b1, 6'd3, TC}      // R7 lowest
  };

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [15:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic rsp_valid, rsp_hit;
  logic [5:0] rsp_idx;
  logic [63:0] rsp_tag;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_assoc u0 (.clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata,
                .rsp_valid, .rsp_hit, .rsp_idx, .rsp_tag);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic lookup(input string req, input logic [63:0] t, input logic h, input logic [5:0] i);
    issue(RD, 16'h0, t);
    check(req, {62'd0, rsp_valid, rsp_hit}, {62'd0, 1'b1, h});
    check(req, {58'd0, rsp_idx}, {58'd0, i});
    check(req, rsp_tag, h ? t : 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    lookup("R1 empty", 64'd0, 1'b0, 6'd0);

    for (int k = 0; k < NV; k++) begin
      issue(TBL[k].op, TBL[k].addr, TBL[k].wd);
      if (TBL[k].chk) begin
        check($sformatf("R7/R8 row %0d valid", k), {63'd0, rsp_valid}, 64'd1);
        check($sformatf("R7/R8 row %0d hit", k), {63'd0, rsp_hit}, {63'd0, TBL[k].hit});
        check($sformatf("R7 row %0d idx", k), {58'd0, rsp_idx}, {58'd0, TBL[k].idx});
        check($sformatf("R7 row %0d tag", k), rsp_tag, TBL[k].tag);
      end
    end

    // R2: an idle cycle with an allocating op must not write
    @(negedge clk); req_op = ALC; req_wdata = V; @(negedge clk);
    lookup("R2 idle", TC, 1'b1, 6'd3);

    do_reset();
    for (int i = 0; i < 64; i++) begin
      issue(STG, 16'h0, 64'h100 + 64'(i));
      issue(ALC, 16'h0, (i == 40) ? V : (V | L));
    end
    lookup("R3 fill last", 64'h13F, 1'b1, 6'd63);
    issue(STG, 16'h0, 64'hDEAD);
    issue(ALC, 16'h0, V);
    lookup("R4 unlocked slot", 64'hDEAD, 1'b1, 6'd40);
    lookup("R4 evicted", 64'h128, 1'b0, 6'd0);
    issue(STG, 16'h0, 64'hBEEF);
    issue(ALC, 16'h0, V | L);
    lookup("R4 reuse", 64'hBEEF, 1'b1, 6'd40);
    issue(STG, 16'h0, 64'hF00D);
    issue(ALC, 16'h0, V);
    lookup("R5 dropped", 64'hF00D, 1'b0, 6'd0);
    lookup("R5 keep 40", 64'hBEEF, 1'b1, 6'd40);
    lookup("R5 keep 0", 64'h100, 1'b1, 6'd0);
    lookup("R5 keep 63", 64'h13F, 1'b1, 6'd63);

    issue(STG, 16'h0, 64'h777);
    issue(DIR, 16'h0, V | L);
    lookup("R6 over locked", 64'h777, 1'b1, 6'd0);
    lookup("R6 old gone", 64'h100, 1'b0, 6'd0);

    issue(DIR, 16'h50, 64'd0);
    issue(DIR, 16'h10, 64'd0);
    lookup("R8 invalid tag", 64'h777, 1'b1, 6'd0);
    issue(STG, 16'h0, 64'hCAFE);
    issue(ALC, 16'h0, V);
    lookup("R3 lowest hole", 64'hCAFE, 1'b1, 6'd2);
    issue(STG, 16'h0, 64'hCAF0);
    issue(ALC, 16'h0, V);
    lookup("R3 next hole", 64'hCAF0, 1'b1, 6'd10);

    do_reset();
    lookup("R1 after reset", 64'h777, 1'b0, 6'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule